// File: doc/BRIEF.md
# Dual Clock Mode Controller

This block holds the clock-mode register of a chip that can run from a fast oscillator, a slow oscillator, or both at once. A four-bit mode field decides three things: which oscillator drives the core, which one drives the idle timer, and which oscillators stay powered. The field holds, from its top bit down, the slow-oscillator enable, the fast-oscillator enable, the dual-clock enable and the core-clock select. Software writes the register over a simple write strobe. The clock multiplexers and oscillators sit outside the block. Here they are only select and enable signals.

Only five mode values are legal, and they form a chain. In order, the chain is fast (0100), fast-to-dual step (1100), dual (1110), dual-to-slow step (1111) and slow (1011). A legal write may move the mode one link along the chain, or leave it where it is. Any value outside the legal set never reaches the selects. Such a write raises a one-cycle reset request and starts a fixed-length hold. Writes are ignored during the hold. When the hold ends, the block returns to fast mode.

The low three bits of the register are an idle-timer configuration field that passes straight to an output. The bit between the two fields is reserved and always reads as zero.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset the mode field is 0100 (fast), the idle configuration is 0, and both rst_req and rst_busy are low.
- R2: rd_data holds the mode field in bits 7:4 (bit 7 slow-oscillator enable, bit 6 fast-oscillator enable, bit 5 dual enable, bit 4 core select) and the idle configuration in bits 2:0.
- R3: core_clk_lo equals mode bit 4 and tmr_clk_lo equals mode bit 5, so the idle timer runs slow in dual mode while the core runs fast.
- R4: lo_osc_en equals mode bit 7 and hi_osc_en equals mode bit 6.
- R5: A legal write that moves at most one link along the chain fast, fast/dual, dual, dual/slow, slow becomes the mode at the clock edge that samples it.
- R6: A write whose bits 7:4 are not one of the five legal values raises rst_req for exactly the one cycle after the write edge, and that value never appears in the mode field.
- R7: After an illegal write, rst_busy stays high for RST_LEN cycles and writes are ignored. When rst_busy falls, the mode is fast and the idle configuration is 0.
- R8: With STRICT_CHAIN set, a legal write that skips a link leaves the mode unchanged but still updates the idle configuration.
- R9: Bit 3 of rd_data is always 0, whatever was written there.
- R10: idle_cfg follows bits 2:0 of the last accepted legal write.
- R11: During the hold, the mode is slow (1011) if the illegal value had dual enable 0 and core select 1. For any other illegal value, the mode is fast (0100).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | CFG_W+5 | Register write value |
| rd_data | output | CFG_W+5 | Register read value |
| core_clk_lo | output | 1 | Core runs from slow oscillator when 1 |
| tmr_clk_lo | output | 1 | Idle timer runs from slow oscillator when 1 |
| lo_osc_en | output | 1 | Slow oscillator enable |
| hi_osc_en | output | 1 | Fast oscillator enable |
| idle_cfg | output | CFG_W | Idle timer configuration |
| rst_req | output | 1 | One-cycle reset request on an illegal write |
| rst_busy | output | 1 | Illegal-write reset hold in progress |

## Verification
The bench builds the block with RST_LEN set to 12 and STRICT_CHAIN set to 1. The short hold lets many illegal writes, and the holds that follow them, fit into one run. Random writes therefore land inside holds, on the cycle a hold ends, and right after it. The strict chain setting makes skip-link writes observable: such a write changes the idle configuration but not the mode.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
   typedef logic [3:0] mode_t;

   localparam mode_t M_FAST  = 4'b0100;
   localparam mode_t M_STEP1 = 4'b1100;
   localparam mode_t M_DUAL  = 4'b1110;
   localparam mode_t M_STEP2 = 4'b1111;
   localparam mode_t M_SLOW  = 4'b1011;

   function automatic logic mode_legal(input mode_t m);
      return (m == M_FAST) || (m == M_STEP1) || (m == M_DUAL) ||
             (m == M_STEP2) || (m == M_SLOW);
   endfunction

   function automatic logic [2:0] mode_rank(input mode_t m);
      case (m)
         M_STEP1: return 3'd1;
         M_DUAL:  return 3'd2;
         M_STEP2: return 3'd3;
         M_SLOW:  return 3'd4;
         default: return 3'd0;
      endcase
   endfunction
endpackage

// File: rtl/clkmode_decode.sv
module clkmode_decode
   import clkmode_pkg::*;
#(
   parameter bit STRICT_CHAIN = 1'b1
) (
   input  mode_t cur_mode,
   input  mode_t new_mode,
   output logic  is_legal,
   output logic  step_ok,
   output mode_t forced_mode
);
   logic [2:0] r_cur, r_new;

   always_comb begin
      is_legal = mode_legal(new_mode);
      r_cur    = mode_rank(cur_mode);
      r_new    = mode_rank(new_mode);
      // dual enable clear with core select set lands in slow mode
      forced_mode = (!new_mode[1] && new_mode[0]) ? M_SLOW : M_FAST;
   end

   generate
      if (STRICT_CHAIN) begin : g_strict
         always_comb begin
            step_ok = is_legal &&
                      ((r_new == r_cur) || (r_new == r_cur + 3'd1) ||
                       (r_cur == r_new + 3'd1));
         end
      end else begin : g_free
         always_comb step_ok = is_legal;
      end
   endgenerate
endmodule

// File: rtl/clkmode_hold.sv
module clkmode_hold #(
   parameter int RST_LEN = 240
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CNT_W = $clog2(RST_LEN + 1);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (start)         cnt_q <= CNT_W'(RST_LEN);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
   assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
   import clkmode_pkg::*;
#(
   parameter int CFG_W        = 3,
   parameter int RST_LEN      = 240,
   parameter bit STRICT_CHAIN = 1'b1,
   localparam int REG_W       = CFG_W + 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic             core_clk_lo,
   output logic             tmr_clk_lo,
   output logic             lo_osc_en,
   output logic             hi_osc_en,
   output logic [CFG_W-1:0] idle_cfg,
   output logic             rst_req,
   output logic             rst_busy
);
   initial begin
      if (CFG_W < 1)   $error("CFG_W must be at least 1");
      if (RST_LEN < 1) $error("RST_LEN must be at least 1");
   end

   mode_t            mode_q, wr_mode, forced;
   logic [CFG_W-1:0] cfg_q;
   logic             req_q, legal, step_ok, accept, hold_done;

   assign wr_mode = wr_data[REG_W-1 -: 4];
   assign accept  = wr_en && !rst_busy;

   clkmode_decode #(.STRICT_CHAIN(STRICT_CHAIN)) u_dec (
      .cur_mode(mode_q), .new_mode(wr_mode),
      .is_legal(legal), .step_ok(step_ok), .forced_mode(forced)
   );

   clkmode_hold #(.RST_LEN(RST_LEN)) u_hold (
      .clk(clk), .rst_n(rst_n), .start(accept && !legal),
      .busy(rst_busy), .done(hold_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= M_FAST;
         cfg_q  <= '0;
         req_q  <= 1'b0;
      end else begin
         req_q <= accept && !legal;
         if (hold_done) begin
            mode_q <= M_FAST;
            cfg_q  <= '0;
         end else if (accept) begin
            if (!legal) begin
               mode_q <= forced;
            end else begin
               cfg_q <= wr_data[CFG_W-1:0];
               if (step_ok) mode_q <= wr_mode;
            end
         end
      end
   end

   assign rd_data     = {mode_q, 1'b0, cfg_q};
   assign core_clk_lo = mode_q[0];
   assign tmr_clk_lo  = mode_q[1];
   assign lo_osc_en   = mode_q[3];
   assign hi_osc_en   = mode_q[2];
   assign idle_cfg    = cfg_q;
   assign rst_req     = req_q;
endmodule

// File: rtl/clkmode_ctrl_chk.sv
module clkmode_ctrl_chk #(
   parameter int REG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [REG_W-1:0] rd_data,
   input logic             core_clk_lo,
   input logic             tmr_clk_lo,
   input logic             rst_req,
   input logic             rst_busy
);
   // R6
   req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);
   // R7
   req_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> rst_busy);
   // R7
   hold_starts_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_busy && !$past(rst_busy)) |-> rst_req);
   // R7
   hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_busy && $past(rst_busy)) |-> $stable(rd_data));
   // R9
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[REG_W-5] == 1'b0);
   // R3
   no_slow_core_fast_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(core_clk_lo && !tmr_clk_lo));
   // R6
   mode_always_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[REG_W-1 -: 4] inside {4'b0100, 4'b1100, 4'b1110, 4'b1111, 4'b1011});
endmodule

bind clkmode_ctrl clkmode_ctrl_chk #(.REG_W(REG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .core_clk_lo(core_clk_lo),
   .tmr_clk_lo(tmr_clk_lo), .rst_req(rst_req), .rst_busy(rst_busy)
);

// File: tb/sim_clkmode_ctrl.sv
module sim_clkmode_ctrl;
   localparam int CLK_P = 10;
   localparam int CFG_W = 3;
   localparam int RLEN  = 12;

   logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic core_clk_lo, tmr_clk_lo, lo_osc_en, hi_osc_en, rst_req, rst_busy;
   logic [2:0] idle_cfg;

   int n_run = 0, n_fail = 0;
   logic [3:0] e_mode;
   logic [2:0] e_cfg;
   logic       e_req;
   int         e_cnt;

   always #(CLK_P/2) clk = ~clk;

   clkmode_ctrl #(.CFG_W(CFG_W), .RST_LEN(RLEN), .STRICT_CHAIN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .core_clk_lo(core_clk_lo), .tmr_clk_lo(tmr_clk_lo),
      .lo_osc_en(lo_osc_en), .hi_osc_en(hi_osc_en), .idle_cfg(idle_cfg),
      .rst_req(rst_req), .rst_busy(rst_busy)
   );

   function automatic bit legal_m(logic [3:0] m);
      return m == 4'b0100 || m == 4'b1100 || m == 4'b1110 ||
             m == 4'b1111 || m == 4'b1011;
   endfunction

   function automatic int pos_m(logic [3:0] m);
      case (m)
         4'b0100: return 0;
         4'b1100: return 1;
         4'b1110: return 2;
         4'b1111: return 3;
         default: return 4;
      endcase
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_all();
      chk("R2 rd_data", rd_data, {e_mode, 1'b0, e_cfg});
      chk("R3 core_clk_lo", core_clk_lo, e_mode[0]);
      chk("R3 tmr_clk_lo", tmr_clk_lo, e_mode[1]);
      chk("R4 lo_osc_en", lo_osc_en, e_mode[3]);
      chk("R4 hi_osc_en", hi_osc_en, e_mode[2]);
      chk("R10 idle_cfg", idle_cfg, e_cfg);
      chk("R6 rst_req", rst_req, e_req);
      chk("R7 rst_busy", rst_busy, e_cnt != 0);
      chk("R9 reserved", rd_data[3], 0);
   endtask

   task automatic model(logic we, logic [7:0] d);
      logic [3:0] m;
      int diff;
      m = d[7:4];
      e_req = 1'b0;
      if (e_cnt != 0) begin
         e_cnt--;
         if (e_cnt == 0) begin e_mode = 4'b0100; e_cfg = '0; end
      end else if (we) begin
         if (!legal_m(m)) begin
            e_req = 1'b1;
            e_cnt = RLEN;
            // R11
            e_mode = (!m[1] && m[0]) ? 4'b1011 : 4'b0100;
         end else begin
            e_cfg = d[2:0];
            diff = pos_m(m) - pos_m(e_mode);
            if (diff >= -1 && diff <= 1) e_mode = m;  // R5 / R8
         end
      end
   endtask

   task automatic cyc(logic we, logic [7:0] d);
      @(negedge clk);
      check_all();
      wr_en = we; wr_data = d;
      @(posedge clk);
      model(we, d);
   endtask

   initial begin
      #(CLK_P * 100000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [3:0] legal_set [5];
      legal_set = '{4'b0100, 4'b1100, 4'b1110, 4'b1111, 4'b1011};
      void'($urandom(32'h5eed));
      e_mode = 4'b0100; e_cfg = '0; e_req = 1'b0; e_cnt = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1 reset state
      chk("R1 mode", rd_data[7:4], 4'b0100);
      chk("R1 cfg", idle_cfg, 0);
      chk("R1 rst_req", rst_req, 0);
      chk("R1 rst_busy", rst_busy, 0);
      // R5 walk the chain down to slow, R9 reserved bit written as 1
      cyc(1, 8'b1100_1_001);
      cyc(1, 8'b1110_0_010);
      cyc(1, 8'b1111_1_011);
      cyc(1, 8'b1011_0_100);
      // R8 skip from slow straight to fast: mode kept, cfg taken
      cyc(1, 8'b0100_0_110);
      cyc(0, 8'h00);
      // R11 illegal with dual enable 0 and core select 1 -> slow during hold
      cyc(1, 8'b0001_0_111);
      // R7 writes during hold ignored
      for (int i = 0; i < RLEN + 2; i++) cyc(1, 8'b1100_0_101);
      // R6 fully illegal value 0000
      cyc(1, 8'b0000_0_011);
      for (int i = 0; i < RLEN + 2; i++) cyc(0, 8'h00);
      // random mix
      for (int i = 0; i < 600; i++) begin
         logic [7:0] d;
         d = 8'($urandom());
         if ($urandom_range(9) < 7) d[7:4] = legal_set[$urandom_range(4)];
         cyc($urandom_range(1), d);
      end
      @(negedge clk);
      check_all();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule